// File: doc/BRIEF.md
# Serial Equalizer Control Word Sender

This block programs a serially loaded equalizer over three output lines: a serial clock, a data line and an active-low latch strobe. A host pulses a start request with two bytes, a band-select byte and a gain byte. The block captures both bytes and shifts the band byte out, least significant bit first. It then pulses the latch strobe. It repeats the same steps for the gain byte and finally reports completion with a one-cycle done pulse.

The serial clock runs only while bits are moving. Each bit lasts `DIV` system clocks: the clock is low for the first `DIV/2` of them and high for the rest. The receiver samples data on the rising edge, so data changes only while the clock is low. While the strobe is low, the clock and data lines are both held low. The strobe low time is `STB_PERIODS` serial periods.

Top module: `eq_word_sender`

## Requirements
- R1: Each word is sent as 8 bits, bit i of the byte being driven on the data line during the i-th serial period (bit 0 first).
- R2: A serial period lasts DIV system clocks (DIV >= 4), with the serial clock low for the first DIV/2 cycles and high for the rest. The data line changes only while the serial clock is low.
- R3: The serial clock is low at all times other than the high phases of the 16 bit periods of an update.
- R4: In the cycle after the last bit period of each word, the strobe output goes low for exactly STB_PERIODS*DIV system clocks. Outside those windows it is high.
- R5: While the strobe is low, the serial clock and data line are both low.
- R6: The band byte is sent first. The first bit period of the gain byte begins in the cycle after the first strobe returns high.
- R7: Both bytes are registered in the cycle start is accepted. Later changes on the byte inputs do not alter the update.
- R8: A start request while busy is high is ignored and does not alter the update in progress.
- R9: Busy is high from the cycle after start is accepted through the done cycle. Done is high for exactly one cycle, the cycle after the second strobe returns high. Busy is low in the following cycle.
- R10: While reset is asserted, serial clock, data, busy and done are low and strobe is high. After reset is released, the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| band_i | input | 8 | Band-select byte |
| gain_i | input | 8 | Gain byte |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Gated serial clock |
| sdata_o | output | 1 | Serial data, bit 0 first |
| lat_no | output | 1 | Active-low latch strobe |

## Verification
A wrong bit index or a wrong shift register value shows up on the data line in the same bit period. A phase counter that drifts moves the next serial clock edge, and the bench compares every cycle, so the error is seen within one system clock. A corrupted state or strobe count shifts the strobe edge, the start of the gain word or the done pulse, and the bench sees this at the first cycle that differs. A byte captured late, or a start accepted while busy, changes the transmitted bits within the next bit period.

// File: rtl/eq_pkg.sv
package eq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2,
    ST_FIN   = 2'd3
  } eq_state_e;
endpackage

// File: rtl/eq_period_cnt.sv
module eq_period_cnt #(
  parameter int unsigned LEN = 4,
  localparam int unsigned W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  assign wrap_o = en_i && (cnt_o == W'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else if (en_i)   cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/eq_bit_shifter.sv
module eq_bit_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             shift_i,
  output logic             lsb_o
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= din_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[WIDTH-1:1]};
  end

  assign lsb_o = sh_q[0];
endmodule

// File: rtl/eq_word_sender.sv
module eq_word_sender
  import eq_pkg::*;
#(
  parameter int unsigned DIV         = 4,
  parameter int unsigned STB_PERIODS = 2,
  parameter int unsigned WORD_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] band_i,
  input  logic [WORD_W-1:0] gain_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              lat_no
);
  localparam int unsigned HALF    = DIV / 2;
  localparam int unsigned STB_CYC = STB_PERIODS * DIV;
  localparam int unsigned PW      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned SW      = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
  localparam int unsigned BW      = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  eq_state_e         state_q;
  logic [BW-1:0]     bit_q;
  logic              second_q;
  logic [WORD_W-1:0] gain_q;
  logic [PW-1:0]     phase;
  logic              phase_wrap;
  logic [SW-1:0]     stb_cnt;
  logic              stb_wrap;
  logic              accept;
  logic              last_bit;
  logic              load_sh;
  logic [WORD_W-1:0] load_val;
  logic              sh_lsb;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign last_bit = (bit_q == BW'(WORD_W - 1));
  assign load_sh  = accept || (stb_wrap && !second_q);
  assign load_val = accept ? band_i : gain_q;

  eq_period_cnt #(.LEN(DIV)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_SHIFT),
    .cnt_o  (phase),
    .wrap_o (phase_wrap)
  );

  eq_period_cnt #(.LEN(STB_CYC)) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_LATCH),
    .cnt_o  (stb_cnt),
    .wrap_o (stb_wrap)
  );

  eq_bit_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_sh),
    .din_i   (load_val),
    .shift_i (phase_wrap && !last_bit),
    .lsb_o   (sh_lsb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      second_q <= 1'b0;
      gain_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_SHIFT;
          bit_q    <= '0;
          second_q <= 1'b0;
          gain_q   <= gain_i;
        end
        ST_SHIFT: if (phase_wrap) begin
          if (last_bit) state_q <= ST_LATCH;
          else          bit_q   <= bit_q + BW'(1);
        end
        ST_LATCH: if (stb_wrap) begin
          if (second_q) state_q <= ST_FIN;
          else begin
            state_q  <= ST_SHIFT;
            bit_q    <= '0;
            second_q <= 1'b1;
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // outputs decoded from registers only
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_FIN);
  assign sclk_o  = (state_q == ST_SHIFT) && (phase >= PW'(HALF));
  assign sdata_o = (state_q == ST_SHIFT) && sh_lsb;
  assign lat_no  = (state_q != ST_LATCH);

  logic unused_ok;
  assign unused_ok = ^stb_cnt;
endmodule

// File: rtl/eq_word_sender_chk.sv
module eq_word_sender_chk #(
  parameter int unsigned LOW_LEN = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic lat_no
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_cnt <= '0;
    else if (!lat_no) low_cnt <= low_cnt + 16'd1;
    else             low_cnt <= '0;
  end

  AST_DATA_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R2
  AST_CLK_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> busy_o); // R3
  AST_STROBE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lat_no) |-> (low_cnt == 16'(LOW_LEN))); // R4
  AST_STROBE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_no |-> (!sclk_o && !sdata_o)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R9
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o)); // R9
  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (lat_no && !sclk_o && !sdata_o && !done_o)); // R10
endmodule

bind eq_word_sender eq_word_sender_chk #(.LOW_LEN(STB_PERIODS * DIV)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sclk_o  (sclk_o),
  .sdata_o (sdata_o),
  .lat_no  (lat_no)
);

// File: tb/sim_eq_word_sender.sv
module sim_eq_word_sender;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int STB = 2;
  localparam int WORD_LEN = 8 * DIV + STB * DIV;
  localparam int TOTAL = 2 * WORD_LEN;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] band_i = '0;
  logic [7:0] gain_i = '0;
  logic busy_o, done_o, sclk_o, sdata_o, lat_no;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eq_word_sender #(.DIV(DIV), .STB_PERIODS(STB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .band_i(band_i),
    .gain_i(gain_i), .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o),
    .sdata_o(sdata_o), .lat_no(lat_no)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {busy,done,sclk,data,lat} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // R10: idle/reset output state
  task automatic check_idle(input string tag);
    check(tag, {busy_o, done_o, sclk_o, sdata_o, lat_no}, 5'b00001);
  endtask

  // one full update; if disturb, start and byte inputs are changed mid-run (R7, R8)
  task automatic run_update(input logic [7:0] b, input logic [7:0] g, input bit disturb);
    logic [4:0] exp;
    string tag;
    @(negedge clk);
    start_i = 1'b1; band_i = b; gain_i = g;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 0; j <= TOTAL + 1; j++) begin
      if (j == TOTAL + 1) begin
        exp = 5'b00001; tag = "R9 idle after done";
      end else if (j == TOTAL) begin
        exp = 5'b11001; tag = "R9 done pulse";
      end else begin
        int w = j / WORD_LEN;
        int t = j % WORD_LEN;
        logic [7:0] byt = (w == 0) ? b : g;
        if (t < 8 * DIV) begin
          int bi = t / DIV;
          int ph = t % DIV;
          exp = {1'b1, 1'b0, (ph >= DIV / 2) ? 1'b1 : 1'b0, byt[bi], 1'b1};
          tag = disturb ? "R1 R2 R3 R6 R7 R8 shift" : "R1 R2 R3 R6 shift";
        end else begin
          exp = 5'b10000;
          tag = "R4 R5 strobe";
        end
      end
      check(tag, {busy_o, done_o, sclk_o, sdata_o, lat_no}, exp);
      if (disturb) begin
        if (j == 5 || j == WORD_LEN + 3 || j == TOTAL - 1) begin
          start_i = 1'b1; band_i = ~b; gain_i = ~g;
        end else begin
          start_i = 1'b0;
        end
      end
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check_idle("R10 during reset");
    start_i = 1'b1;
    #(CLK_PERIOD * 2);
    check_idle("R10 start held in reset");
    start_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R10 idle after reset");

    run_update(8'h00, 8'hFF, 0);
    run_update(8'hFF, 8'h00, 0);
    run_update(8'hA5, 8'h3C, 1);
    for (int i = 0; i < 8; i++) run_update(8'h01 << i, 8'h80 >> i, i[0]);
    for (int i = 0; i < 16; i++)
      run_update(8'(i * 8'h1B) ^ 8'h5A, 8'(i * 37 + 3), i[1]);

    // R10: reset in the middle of an update
    @(negedge clk);
    start_i = 1'b1; band_i = 8'hC3; gain_i = 8'h96;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8 * DIV + 2) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_idle("R10 reset mid update");
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_idle("R10 stays idle after mid reset");
    end
    run_update(8'h69, 8'h96, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule